// File: doc/BRIEF.md
# SPI ADC Acquisition Sequencer

This block runs a 16-bit successive-approximation converter over a 4-wire serial link with no busy indication. It starts one conversion every `CYC_CLKS` system clocks by raising the convert strobe. In each cycle it runs one 16-clock exchange: it shifts out a configuration word that selects the next channel and shifts in the previous result. The serial clock idles low and uses mode 0. The exchange runs either after the conversion ends or while the conversion is still running. `mode_i` picks the timing and is sampled at the start of each cycle.

The converter applies a configuration two exchanges after it is written. The block therefore keeps a two-deep history of the channels it has sent, and it tags each result with the channel that actually produced it. Results read before the converter holds a valid setup are dropped, so the caller only sees tagged, usable samples. Channels come from a fixed sequence vector that is visited cyclically.

Top module: `adc_acq_seq`

## Requirements
- R1: `sck_o` is low whenever no exchange is running, and it is always low while `cnv_o` is high.
- R2: Each exchange gives exactly 16 rising edges on `sck_o`. `din_o` changes only while `sck_o` is low, and `sdo_i` is captured on the rising edges, MSB first.
- R3: `cnv_o` rises every `CYC_CLKS` clocks, and it is high at the clock `CONV_CLKS` after each rise, when the conversion ends.
- R4: In after-conversion timing (`mode_i`=0), `cnv_o` falls and the exchange starts `CONV_CLKS`+2 clocks after the rise of `cnv_o`.
- R5: In during-conversion timing (`mode_i`=1), `cnv_o` falls 3 clocks after it rises, and the exchange ends before the conversion ends.
- R6: The word sent in exchange t is: bit 15 = 1 (apply), bits 14:12 = entry t mod 4 of `seq_i` (entry e in bits 3e+2:3e), and bits 11:0 = `CFG_TAIL`.
- R7: The results of the first three exchanges after reset are never presented.
- R8: The result of exchange t carries the channel sent in exchange t-2 on `res_chan_o`, and `res_data_o` holds the 16 bits read in that exchange.
- R9: `res_valid_o` is a single-clock pulse. It is high from clock edge t*`CYC_CLKS` + L + 32*`SCK_DIV` + 3 after reset release, where L = `CONV_CLKS`+1 in mode 0 and L = 2 in mode 1.
- R10: A change of `mode_i` inside a cycle takes effect only from the next rise of `cnv_o`.
- R11: While `rst_ni` is low, `cnv_o`, `sck_o`, `din_o` and `res_valid_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 0: exchange after conversion, 1: exchange during conversion |
| seq_i | input | SEQ_LEN*CH_W | Channel sequence, entry 0 in the low bits |
| cnv_o | output | 1 | Convert strobe to the converter |
| sck_o | output | 1 | Serial clock, idles low |
| din_o | output | 1 | Configuration data to the converter |
| sdo_i | input | 1 | Result data from the converter |
| res_valid_o | output | 1 | One-clock strobe for a result |
| res_data_o | output | DATA_W | Result word |
| res_chan_o | output | CH_W | Channel the result belongs to |

## Verification
Each result is due at a fixed clock edge, counted from reset release. The count is the cycle index times `CYC_CLKS`, plus the mode's launch offset, plus 32*`SCK_DIV` for the serial exchange, plus three register stages. The bench counts edges itself and requires every strobe to arrive at exactly that edge. It checks the strobe, tag and data on the falling clock edge that follows. The converter model in the bench times the fall of the convert strobe against its own record of the previous rise, using the mode it saw at that rise. This means a mode change takes effect one cycle late, and the check expects exactly that.

// File: rtl/acq_seq_pkg.sv
package acq_seq_pkg;
  typedef enum logic {
    ACQ_AFTER  = 1'b0,
    ACQ_DURING = 1'b1
  } acq_mode_e;

  // results discarded after reset while the converter setup settles
  localparam int unsigned SKIP_RESULTS = 3;
  // launch point of an exchange in during-conversion timing
  localparam int unsigned DURING_LAUNCH = 2;
endpackage

// File: rtl/acq_phase_timer.sv
module acq_phase_timer
  import acq_seq_pkg::*;
#(
  parameter int unsigned CONV_CLKS = 80,
  parameter int unsigned CYC_CLKS  = 160
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mode_i,
  input  logic xfer_done_i,
  output logic start_o,
  output logic cnv_o
);
  localparam int unsigned CNT_W        = $clog2(CYC_CLKS);
  localparam int unsigned AFTER_LAUNCH = CONV_CLKS + 1;

  logic [CNT_W-1:0] cnt_q;
  acq_mode_e        mode_q;
  logic             cnv_q;
  logic             wrap;

  assign wrap    = (cnt_q == CNT_W'(CYC_CLKS - 1));
  assign start_o = (cnt_q == CNT_W'((mode_q == ACQ_DURING) ? DURING_LAUNCH : AFTER_LAUNCH));
  assign cnv_o   = cnv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= CNT_W'(CYC_CLKS - 1);
      mode_q <= ACQ_AFTER;
      cnv_q  <= 1'b0;
    end else if (wrap) begin
      cnt_q  <= '0;
      mode_q <= acq_mode_e'(mode_i);
      cnv_q  <= 1'b1;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
      // low one clock before each start so the next rise marks it
      if (cnt_q == CNT_W'(CYC_CLKS - 2) || start_o) cnv_q <= 1'b0;
      else if (xfer_done_i)                         cnv_q <= 1'b1;
    end
  end

  p_cnv_high_eoc_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_W'(CONV_CLKS)) |-> cnv_q);
endmodule

// File: rtl/acq_spi_xfer.sv
module acq_spi_xfer #(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned SCK_DIV = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] tx_i,
  input  logic              sdo_i,
  output logic              sck_o,
  output logic              din_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_o
);
  localparam int unsigned HC_W = $clog2(SCK_DIV + 1);
  localparam int unsigned EC_W = $clog2(2 * DATA_W);

  logic [HC_W-1:0]   hc_q;
  logic [EC_W-1:0]   ec_q;
  logic [DATA_W-1:0] tx_q, rx_q;
  logic              sck_q, din_q, busy_q, done_q;

  assign sck_o  = sck_q;
  assign din_o  = din_q;
  assign busy_o = busy_q;
  assign done_o = done_q;
  assign rx_o   = rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hc_q   <= '0;
      ec_q   <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
      sck_q  <= 1'b0;
      din_q  <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !busy_q) begin
        busy_q <= 1'b1;
        sck_q  <= 1'b0;
        hc_q   <= '0;
        ec_q   <= '0;
        din_q  <= tx_i[DATA_W-1];
        tx_q   <= {tx_i[DATA_W-2:0], 1'b0};
      end else if (busy_q) begin
        if (hc_q == HC_W'(SCK_DIV - 1)) begin
          hc_q <= '0;
          ec_q <= ec_q + EC_W'(1);
          if (!sck_q) begin
            sck_q <= 1'b1;
            rx_q  <= {rx_q[DATA_W-2:0], sdo_i};
          end else begin
            sck_q <= 1'b0;
            din_q <= tx_q[DATA_W-1];
            tx_q  <= {tx_q[DATA_W-2:0], 1'b0};
            if (ec_q == EC_W'(2 * DATA_W - 1)) begin
              busy_q <= 1'b0;
              done_q <= 1'b1;
            end
          end
        end else begin
          hc_q <= hc_q + HC_W'(1);
        end
      end
    end
  end

  p_din_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_q |-> $stable(din_q));
endmodule

// File: rtl/acq_tag_pipe.sv
module acq_tag_pipe
  import acq_seq_pkg::*;
#(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned CH_W    = 3,
  parameter int unsigned SEQ_LEN = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [SEQ_LEN*CH_W-1:0] seq_i,
  input  logic                    start_i,
  input  logic                    done_i,
  input  logic [DATA_W-1:0]       rx_i,
  output logic [CH_W-1:0]         cur_chan_o,
  output logic                    res_valid_o,
  output logic [DATA_W-1:0]       res_data_o,
  output logic [CH_W-1:0]         res_chan_o
);
  localparam int unsigned IDX_W  = (SEQ_LEN > 1) ? $clog2(SEQ_LEN) : 1;
  localparam int unsigned SKIP_W = $clog2(SKIP_RESULTS + 1);

  logic [IDX_W-1:0]  idx_q;
  logic [CH_W-1:0]   sent_q, hist1_q, hist2_q;
  logic [SKIP_W-1:0] seen_q;
  logic [CH_W-1:0]   seq_arr [SEQ_LEN];

  for (genvar e = 0; e < SEQ_LEN; e++) begin : g_seq
    assign seq_arr[e] = seq_i[e*CH_W +: CH_W];
  end

  assign cur_chan_o = seq_arr[idx_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q       <= '0;
      sent_q      <= '0;
      hist1_q     <= '0;
      hist2_q     <= '0;
      seen_q      <= '0;
      res_valid_o <= 1'b0;
      res_data_o  <= '0;
      res_chan_o  <= '0;
    end else begin
      res_valid_o <= 1'b0;
      if (start_i) begin
        sent_q  <= cur_chan_o;
        hist1_q <= sent_q;
        hist2_q <= hist1_q;
        idx_q   <= (idx_q == IDX_W'(SEQ_LEN - 1)) ? '0 : idx_q + IDX_W'(1);
      end
      if (done_i) begin
        if (seen_q == SKIP_W'(SKIP_RESULTS)) begin
          res_valid_o <= 1'b1;
          res_data_o  <= rx_i;
          res_chan_o  <= hist2_q;
        end else begin
          seen_q <= seen_q + SKIP_W'(1);
        end
      end
    end
  end

  p_valid_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |=> !res_valid_o);
endmodule

// File: rtl/adc_acq_seq.sv
module adc_acq_seq
  import acq_seq_pkg::*;
#(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned CH_W      = 3,
  parameter int unsigned SEQ_LEN   = 4,
  parameter int unsigned SCK_DIV   = 2,
  parameter int unsigned CONV_CLKS = 80,
  parameter int unsigned CYC_CLKS  = 160,
  parameter int unsigned CFG_TAIL  = 'hC91
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    mode_i,
  input  logic [SEQ_LEN*CH_W-1:0] seq_i,
  output logic                    cnv_o,
  output logic                    sck_o,
  output logic                    din_o,
  input  logic                    sdo_i,
  output logic                    res_valid_o,
  output logic [DATA_W-1:0]       res_data_o,
  output logic [CH_W-1:0]         res_chan_o
);
  localparam int unsigned TAIL_W = DATA_W - 1 - CH_W;

  logic              start, busy, done;
  logic [DATA_W-1:0] rx_word, tx_word;
  logic [CH_W-1:0]   cur_chan;

  assign tx_word = {1'b1, cur_chan, TAIL_W'(CFG_TAIL)};

  acq_phase_timer #(.CONV_CLKS(CONV_CLKS), .CYC_CLKS(CYC_CLKS)) u_timer (
    .clk_i, .rst_ni, .mode_i,
    .xfer_done_i (done),
    .start_o     (start),
    .cnv_o
  );

  acq_spi_xfer #(.DATA_W(DATA_W), .SCK_DIV(SCK_DIV)) u_xfer (
    .clk_i, .rst_ni,
    .start_i (start),
    .tx_i    (tx_word),
    .sdo_i,
    .sck_o, .din_o,
    .busy_o  (busy),
    .done_o  (done),
    .rx_o    (rx_word)
  );

  acq_tag_pipe #(.DATA_W(DATA_W), .CH_W(CH_W), .SEQ_LEN(SEQ_LEN)) u_tags (
    .clk_i, .rst_ni, .seq_i,
    .start_i    (start),
    .done_i     (done),
    .rx_i       (rx_word),
    .cur_chan_o (cur_chan),
    .res_valid_o, .res_data_o, .res_chan_o
  );

  p_sck_low_cnv_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnv_o |-> !sck_o);
  p_start_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |-> !busy);
  p_valid_after_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> $past(done));
endmodule

// File: tb/sim_adc_acq_seq.sv
`timescale 1ns/1ps
module sim_adc_acq_seq;
  localparam int DW = 16, CHW = 3, SEQN = 4, DIV = 2;
  localparam int CONV = 80, CYC = 160, TAIL = 'hC91;
  localparam int LOWW = DW - CHW;

  typedef struct packed {
    logic        mode;
    logic [11:0] seq;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{1'b0, 12'o3210},
    '{1'b1, 12'o1357},
    '{1'b0, 12'o4266},
    '{1'b1, 12'o4702}
  };

  logic clk = 0, rst_n = 0, mode = 0, sdo = 0;
  logic [SEQN*CHW-1:0] seq = '0;
  logic cnv, sck, din, vld;
  logic [DW-1:0] dat;
  logic [CHW-1:0] chn;

  adc_acq_seq #(.DATA_W(DW), .CH_W(CHW), .SEQ_LEN(SEQN), .SCK_DIV(DIV),
    .CONV_CLKS(CONV), .CYC_CLKS(CYC), .CFG_TAIL(TAIL)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .seq_i(seq),
    .cnv_o(cnv), .sck_o(sck), .din_o(din), .sdo_i(sdo),
    .res_valid_o(vld), .res_data_o(dat), .res_chan_o(chn));

  always #2.5 clk = ~clk;

  int n_chk = 0, n_err = 0;
  int ecount = 0;
  bit chk_data = 0, done_flag = 0;
  int k_out = 0;
  bit prev_vld = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int launch(input logic m);
    return m ? 2 : CONV + 1;
  endfunction

  function automatic logic [CHW-1:0] seq_ch(input int t);
    return seq[(t % SEQN)*CHW +: CHW];
  endfunction

  always @(posedge clk) if (!rst_n) ecount = 0; else ecount++;

  // converter model
  logic [DW-1:0] m_out, m_sh, m_din;
  logic [CHW-1:0] m_ch;
  int m_eoc, m_xfer, m_rise, m_soc_e, m_prev_soc;
  bit m_inx, m_armed, m_cfg_ok;
  logic m_mode;
  event soc_ev;

  task automatic model_clear();
    m_out = '0; m_sh = '0; m_din = '0; m_ch = '0;
    m_eoc = 0; m_xfer = 0; m_rise = 0; m_soc_e = 0; m_prev_soc = -1;
    m_inx = 0; m_armed = 0; m_cfg_ok = 0; m_mode = 0; sdo = 0; k_out = 0;
  endtask

  always @(posedge cnv) if (rst_n) begin
    if (m_inx) begin
      m_inx = 0;
      chk(m_rise == 16, "R2 sck rises", m_rise, 16);
      if (chk_data)
        chk(m_din == {1'b1, seq_ch(m_xfer), 12'(TAIL)}, "R6 cfg word", m_din,
            {1'b1, seq_ch(m_xfer), 12'(TAIL)});
      m_cfg_ok = 1;
      m_xfer++;
    end else begin
      m_armed = 1;
      m_mode = mode;
      if (m_prev_soc >= 0) chk(ecount - m_prev_soc == CYC, "R3 period", ecount - m_prev_soc, CYC);
      m_prev_soc = ecount;
      m_soc_e = ecount;
      -> soc_ev;
    end
  end

  always begin
    @(soc_ev);
    #(CONV * 5.0 - 1.0);
    if (rst_n) begin
      chk(cnv == 1'b1, "R3 cnv at eoc", cnv, 1);
      if (m_mode) chk(!m_inx, "R5 exchange before eoc", m_inx, 0);
      m_out = {m_ch, LOWW'(m_eoc)};
      if (m_cfg_ok && m_din[DW-1]) m_ch = m_din[DW-2 -: CHW];
      m_cfg_ok = 0;
      m_eoc++;
    end
  end

  always @(negedge cnv) if (rst_n && m_armed) begin
    m_armed = 0;
    chk(ecount - m_soc_e == launch(m_mode) + 1, m_mode ? "R5 launch" : "R4 launch",
        ecount - m_soc_e, launch(m_mode) + 1);
    m_inx = 1; m_rise = 0; m_din = '0;
    m_sh = m_out; sdo = m_out[DW-1];
  end

  always @(posedge sck) if (m_inx) begin
    m_din = {m_din[DW-2:0], din};
    m_rise++;
  end

  always @(negedge sck) if (m_inx) begin
    m_sh = {m_sh[DW-2:0], 1'b0};
    sdo = m_sh[DW-1];
  end

  // result checks on the falling clock edge
  always @(negedge clk) begin
    if (!rst_n) begin
      if (ecount == 0 && !done_flag) begin end
    end else begin
      if (prev_vld) chk(!vld, "R9 single pulse", vld, 0);
      if (vld && chk_data) begin
        int t, ee;
        t = k_out + 3;
        ee = t * CYC + launch(m_mode) + 32 * DIV + 3;
        chk(ecount == ee, "R9 strobe edge", ecount, ee);
        chk(chn == seq_ch(t - 2), "R8 tag", chn, seq_ch(t - 2));
        chk(dat == {seq_ch(t - 2), LOWW'(m_mode ? t - 1 : t)}, "R8 data", dat,
            {seq_ch(t - 2), LOWW'(m_mode ? t - 1 : t)});
      end
      if (vld) k_out++;
      prev_vld = vld;
    end
  end

  task automatic do_reset(input logic md, input logic [11:0] sq);
    rst_n = 0;
    repeat (200) @(negedge clk);
    chk({cnv, sck, din, vld} == 4'b0, "R11 reset outputs", {cnv, sck, din, vld}, 0);
    mode = md; seq = sq; prev_vld = 0;
    model_clear();
    rst_n = 1;
  endtask

  initial begin
    #(200000 * 5.0);
    if (!done_flag) begin
      done_flag = 1;
      n_err++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    model_clear();
    // vector table
    for (int v = 0; v < 4; v++) begin
      chk_data = 1;
      do_reset(VECS[v].mode, VECS[v].seq);
      repeat (9 * CYC + 10) @(negedge clk);
      chk(k_out == 6, "R7 results after discard", k_out, 6);
    end
    // directed: no strobe during the first three exchanges
    chk_data = 1;
    do_reset(1'b0, 12'o0123);
    repeat (3 * CYC + 1) @(negedge clk);
    chk(k_out == 0, "R7 no early result", k_out, 0);
    chk(!sck && cnv, "R1 idle sck low", sck, 0);
    // directed: mode change inside a cycle
    chk_data = 0;
    do_reset(1'b0, 12'o7531);
    repeat (2 * CYC + 60) @(negedge clk);
    mode = 1'b1;
    repeat (3 * CYC) @(negedge clk);
    mode = 1'b0;
    repeat (2 * CYC + 20) @(negedge clk);
    chk(m_xfer >= 6, "R10 exchanges continue", m_xfer, 6);
    if (!done_flag) begin
      done_flag = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end
endmodule